// File: doc/BRIEF.md
# Fail-on-First Vector Length Truncator

A vector instruction is executed as a run of scalar element operations, each reporting its index and result back to this block as it finishes. When the first element fails, the block shortens the active vector length (VL) so that only the legal leading elements take effect. The vector operation keeps running in its vector form and never drops to a scalar fallback. There are two kinds of failure. In load mode, an element whose memory access faults is a failure. In ALU mode, an element whose result is zero is a failure, but only when the instruction's fail-first enable bit is set.

Truncation rewrites VL itself. Results are not tagged as invalid and passed on. Elements may finish out of order. The block tracks the lowest failing index seen so far, called the cut point, and drives a per-element kill mask from it at once. The new VL is committed only when every element below the cut point has completed. A fault on element 0 of a load cannot be truncated away, so it is reported as a precise trap and VL is left alone. A start pulse opens each instruction, loads its VL and mode, and clears all pending state.

Top module: `ffirst_vl_trunc`

## Requirements
- R1: After reset, vl_out is 0, every kill_mask bit is 1, and trap and vl_update are 0.
- R2: A start pulse makes vl_out equal to vl_in (clamped to MAXVL) on the next cycle. It sets kill_mask bit i exactly when i >= that VL and clears any pending failure.
- R3: In load mode (start with ld_mode=1), an accepted element k > 0 with elem_fault=1 sets kill_mask bits k and above on the cycle after acceptance. kill_mask bits never clear except on start.
- R4: The cut point is the lowest failing index. A failure above the current cut point changes nothing, and a failure below it lowers it.
- R5: The new VL is committed only after every element below the cut point has been accepted. vl_out then becomes the cut index one cycle after the last of those elements is accepted.
- R6: In ALU mode (ld_mode=0) with ffirst=1, a zero elem_result is a failure. Element 0 being zero gives a VL of 0.
- R7: In ALU mode with ffirst=0, zero results have no effect on kill_mask or vl_out.
- R8: In load mode, an element 0 fault raises trap for exactly one cycle, on the cycle after acceptance, and leaves vl_out and kill_mask unchanged. trap and vl_update are never high together.
- R9: Only elem_fault counts as a failure in load mode, and only a zero result counts in ALU mode. The other one is ignored.
- R10: Elements with an index at or above the current cut point or VL are ignored.
- R11: vl_update pulses for one cycle, in the same cycle that vl_out drops to the committed value, and only then. Without start, vl_out never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new vector instruction |
| vl_in | input | LW | Initial vector length, sampled on start |
| ld_mode | input | 1 | 1 = load instruction, 0 = ALU instruction, sampled on start |
| ffirst | input | 1 | Enables the zero check in ALU mode, sampled on start |
| elem_valid | input | 1 | An element result is reported this cycle |
| elem_idx | input | IW | Index of the reported element |
| elem_result | input | DW | Result value of the element |
| elem_fault | input | 1 | Memory access of the element faulted |
| vl_out | output | LW | Current, possibly truncated, vector length |
| kill_mask | output | MAXVL | Bit i set suppresses element i |
| trap | output | 1 | One-cycle precise trap for an element 0 load fault |
| vl_update | output | 1 | One-cycle pulse when a truncated VL is committed |

## Verification
In-order load faults show the basic cut, and the gap between mask update and VL commit. Out-of-order arrivals tell apart a design that commits at once from one that waits for the lower elements, and show that the lowest failure wins. Some patterns put zero data into load mode and fault flags into ALU mode, or turn the fail-first bit off. These show that each mode looks only at its own failure condition. The corner cases are element 0 in both modes, indices beyond VL, oversized vl_in, and a restart with a failure still pending.

// File: rtl/ffirst_vl_trunc.sv
module ffirst_vl_trunc #(
  parameter int MAXVL = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(MAXVL),
  localparam int LW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LW-1:0]    vl_in,
  input  logic             ld_mode,
  input  logic             ffirst,
  input  logic             elem_valid,
  input  logic [IW-1:0]    elem_idx,
  input  logic [DW-1:0]    elem_result,
  input  logic             elem_fault,
  output logic [LW-1:0]    vl_out,
  output logic [MAXVL-1:0] kill_mask,
  output logic             trap,
  output logic             vl_update
);

  logic [LW-1:0]    vl_q, cut_q;
  logic             ld_q, ff_q, trap_q, upd_q;
  logic [MAXVL-1:0] done_q;
  logic             lower_ok;

  wire [LW-1:0] idx_w    = LW'(elem_idx);
  wire [LW-1:0] vl_clamp = (vl_in > LW'(MAXVL)) ? LW'(MAXVL) : vl_in;
  wire take     = elem_valid && !start && (idx_w < cut_q) && !done_q[elem_idx];
  wire fail     = ld_q ? elem_fault : (ff_q && (elem_result == '0));
  wire hit      = take && fail;
  wire trap_hit = hit && ld_q && (idx_w == '0);
  wire cut_hit  = hit && !trap_hit;
  wire commit   = (cut_q < vl_q) && lower_ok;

  always_comb begin
    lower_ok = 1'b1;
    for (int i = 0; i < MAXVL; i++)
      if (LW'(i) < cut_q && !done_q[i]) lower_ok = 1'b0;
  end

  genvar g;
  generate
    for (g = 0; g < MAXVL; g++) begin : g_kill
      assign kill_mask[g] = (LW'(g) >= cut_q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q   <= '0;
      cut_q  <= '0;
      ld_q   <= 1'b0;
      ff_q   <= 1'b0;
      done_q <= '0;
      trap_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      trap_q <= trap_hit;
      upd_q  <= 1'b0;
      if (start) begin
        vl_q   <= vl_clamp;
        cut_q  <= vl_clamp;
        ld_q   <= ld_mode;
        ff_q   <= ffirst;
        done_q <= '0;
      end else begin
        if (take) done_q[elem_idx] <= 1'b1;
        if (cut_hit) cut_q <= idx_w;
        if (commit) begin
          vl_q  <= cut_q;
          upd_q <= 1'b1;
        end
      end
    end
  end

  assign vl_out    = vl_q;
  assign trap      = trap_q;
  assign vl_update = upd_q;

endmodule

// File: rtl/ffirst_vl_trunc_chk.sv
module ffirst_vl_trunc_chk #(
  parameter int MAXVL = 16,
  localparam int LW   = $clog2(MAXVL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LW-1:0]    vl_in,
  input logic [LW-1:0]    vl_out,
  input logic [MAXVL-1:0] kill_mask,
  input logic             trap,
  input logic             vl_update
);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (vl_out == (($past(vl_in) > LW'(MAXVL)) ? LW'(MAXVL) : $past(vl_in))));

  // R3
  kill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((kill_mask & $past(kill_mask)) == $past(kill_mask)));

  // R11
  vl_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (vl_out <= $past(vl_out)));

  // R11
  update_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_update |-> (vl_out < $past(vl_out)));

  // R8
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !vl_update);

  // R8
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !trap);

endmodule

bind ffirst_vl_trunc ffirst_vl_trunc_chk #(.MAXVL(MAXVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .vl_out(vl_out),
  .kill_mask(kill_mask), .trap(trap), .vl_update(vl_update)
);

// File: tb/tb_ffirst_vl_trunc.sv
`timescale 1ns/1ps
module tb_ffirst_vl_trunc;
  localparam int MAXVL = 16;
  localparam int DW    = 32;
  localparam int IW    = $clog2(MAXVL);
  localparam int LW    = $clog2(MAXVL + 1);

  logic clk = 0, rst_n = 0, start = 0, ld_mode = 0, ffirst = 0;
  logic elem_valid = 0, elem_fault = 0;
  logic [LW-1:0] vl_in = '0;
  logic [IW-1:0] elem_idx = '0;
  logic [DW-1:0] elem_result = '0;
  logic [LW-1:0] vl_out;
  logic [MAXVL-1:0] kill_mask;
  logic trap, vl_update;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  ffirst_vl_trunc #(.MAXVL(MAXVL), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .ld_mode(ld_mode),
    .ffirst(ffirst), .elem_valid(elem_valid), .elem_idx(elem_idx),
    .elem_result(elem_result), .elem_fault(elem_fault), .vl_out(vl_out),
    .kill_mask(kill_mask), .trap(trap), .vl_update(vl_update));

  function automatic logic [MAXVL-1:0] km(int n);
    logic [MAXVL-1:0] m = '0;
    for (int i = 0; i < MAXVL; i++) m[i] = (i >= n);
    return m;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic begin_op(int vl, bit ld, bit ff);
    @(negedge clk);
    start = 1; vl_in = LW'(vl); ld_mode = ld; ffirst = ff;
    @(negedge clk);
    start = 0;
  endtask

  task automatic elem(int idx, int res, bit flt);
    @(negedge clk);
    elem_valid = 1; elem_idx = IW'(idx); elem_result = DW'(res); elem_fault = flt;
    @(negedge clk);
    elem_valid = 0; elem_fault = 0;
  endtask

  task automatic t_reset();
    chk("R1 vl_out", vl_out, 0);
    chk("R1 kill_mask", kill_mask, km(0));
    chk("R1 trap", trap, 0);
    chk("R1 vl_update", vl_update, 0);
  endtask

  task automatic t_start();
    begin_op(10, 1, 0);
    chk("R2 vl_out", vl_out, 10);
    chk("R2 kill_mask", kill_mask, km(10));
    begin_op(20, 1, 0);
    chk("R2 clamp vl", vl_out, MAXVL);
    chk("R2 clamp mask", kill_mask, km(MAXVL));
  endtask

  task automatic t_load_inorder();
    begin_op(10, 1, 0);
    elem(0, 1, 0); elem(1, 1, 0); elem(2, 1, 0);
    elem(3, 1, 1);
    chk("R3 kill after fault", kill_mask, km(3));
    idle();
    chk("R5 vl committed", vl_out, 3);
    chk("R11 update pulse", vl_update, 1);
    idle();
    chk("R11 update one cycle", vl_update, 0);
  endtask

  task automatic t_out_of_order();
    begin_op(12, 1, 0);
    elem(5, 1, 1);
    chk("R3 kill at 5", kill_mask, km(5));
    elem(7, 1, 1);
    chk("R4 higher fault ignored", kill_mask, km(5));
    elem(2, 1, 1);
    chk("R4 lower fault wins", kill_mask, km(2));
    idle();
    chk("R5 wait for lower", vl_out, 12);
    elem(1, 1, 0); idle();
    chk("R5 still waiting", vl_out, 12);
    chk("R11 no update yet", vl_update, 0);
    elem(0, 1, 0); idle();
    chk("R5 commit after lower done", vl_out, 2);
    chk("R11 update on commit", vl_update, 1);
  endtask

  task automatic t_alu_zero();
    begin_op(8, 0, 1);
    elem(0, 5, 0);
    elem(2, 7, 1);
    chk("R9 fault ignored in ALU", kill_mask, km(8));
    elem(1, 0, 0);
    chk("R6 zero cuts mask", kill_mask, km(1));
    idle();
    chk("R6 zero cuts vl", vl_out, 1);
    begin_op(8, 0, 1);
    elem(0, 0, 0); idle();
    chk("R6 elem0 zero vl", vl_out, 0);
    chk("R6 elem0 zero mask", kill_mask, km(0));
  endtask

  task automatic t_alu_off();
    begin_op(8, 0, 0);
    for (int i = 0; i < 8; i++) begin
      elem(i, 0, 0);
      chk("R7 no update", vl_update, 0);
    end
    idle();
    chk("R7 vl kept", vl_out, 8);
    chk("R7 mask kept", kill_mask, km(8));
  endtask

  task automatic t_trap();
    begin_op(6, 1, 0);
    elem(0, 1, 1);
    chk("R8 trap high", trap, 1);
    chk("R8 mask kept", kill_mask, km(6));
    idle();
    chk("R8 trap one cycle", trap, 0);
    chk("R8 vl kept", vl_out, 6);
  endtask

  task automatic t_load_zero();
    begin_op(5, 1, 1);
    elem(2, 0, 0); idle();
    chk("R9 zero load not failure mask", kill_mask, km(5));
    chk("R9 zero load not failure vl", vl_out, 5);
  endtask

  task automatic t_beyond();
    begin_op(4, 0, 1);
    elem(6, 0, 0); idle();
    chk("R10 beyond vl mask", kill_mask, km(4));
    chk("R10 beyond vl", vl_out, 4);
  endtask

  task automatic t_restart();
    begin_op(9, 1, 0);
    elem(4, 1, 1);
    chk("R3 pending cut", kill_mask, km(4));
    begin_op(9, 1, 0);
    chk("R2 restart clears", kill_mask, km(9));
    elem(0, 1, 0); elem(1, 1, 0); elem(2, 1, 0); elem(3, 1, 0); idle();
    chk("R2 no stale commit", vl_out, 9);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        idle();
        t_reset();
        t_start();
        t_load_inorder();
        t_out_of_order();
        t_alu_zero();
        t_alu_off();
        t_trap();
        t_load_zero();
        t_beyond();
        t_restart();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule